// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Debugger Hold

This block turns three active-low external reset requests into the internal reset domains of a chip: a debug/emulation domain, a system domain and one reset per processor core. The three requests have different reach. The power-on request clears everything and floats the pads. The full request clears the same logic but leaves the pads driven. The warm request clears only the system domain and the cores. Software can block the warm request, and it never touches the debug domain. Every request passes through a synchronizer that asserts at once and releases on the clock. Each internal reset is a register on the clock, so all reset edges are synchronous and need a running clock.

When a hard request (power-on or full) ends, the block gives a one-cycle strobe that the boot-mode capture logic uses. When the power-on request ends, it samples two strap pins. One strap pattern selects a wait-in-reset mode. In that mode every core stays in reset after the system domain is released, and a debugger frees each core with its own release pulse. A small configuration register holds the warm-reset block bit and one halt-on-reset bit per core. A core whose bit is set leaves reset with its halt output high, and it stays halted until the debugger sends a release pulse.

Top module: `rstctl_top`

## Requirements
- R1: While the synchronized power-on request is active, `pad_tristate` is high and `dbg_rst_n`, `sys_rst_n` and every `core_rst_n` bit are low. All of them are registered, so they reach these values on clock edges only.
- R2: A full request (`full_n` low) drives `dbg_rst_n`, `sys_rst_n` and `core_rst_n` low, and `pad_tristate` stays low throughout.
- R3: `boot_latch` is high for exactly one cycle, the same cycle in which `dbg_rst_n` rises after a power-on or full request ends. It never pulses for a warm request.
- R4: A warm request (`warm_n` low) drives `sys_rst_n` low at the first edge and `core_rst_n` low at the second edge. When bit 0 of the configuration register is 1, the warm request has no effect on any output.
- R5: A warm request never lowers `dbg_rst_n`, and the configuration register keeps its value through it.
- R6: After the last active request rises, `dbg_rst_n` rises at the third clock edge (two synchronizer stages plus the output register). `sys_rst_n` rises one edge later. A core that is not held rises one edge after that.
- R7: `dbg_strap` is sampled when the power-on request ends. The value 2'b10 (bit 1 high, bit 0 low) enables wait-in-reset, and any other value disables it. Only a later power-on request changes this setting. In wait-in-reset, core i stays in reset after `sys_rst_n` rises until a `dbg_release[i]` pulse arrives, and the core rises at the edge that samples the pulse. Release pulses seen while `sys_rst_n` is low are ignored, and every system reset holds the cores again.
- R8: Core i leaves reset with `core_halt[i]` equal to configuration bit i+1. A `dbg_release[i]` pulse while the core is out of reset clears `core_halt[i]` at the next edge.
- R9: A write (`cfg_we` high) loads `cfg_wdata` into the configuration register at the next edge, and `cfg_rdata` shows its value. A power-on or full request clears the register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all reset propagation |
| por_n | input | 1 | Power-on request, active low, asynchronous |
| full_n | input | 1 | Full hard request, active low, asynchronous |
| warm_n | input | 1 | Maskable warm request, active low, asynchronous |
| dbg_strap | input | 2 | Emulation strap pins, sampled when the power-on request ends |
| dbg_release | input | NCORE | Per-core debugger release pulse |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | NCORE+1 | Write data: bit 0 blocks warm, bit i+1 is halt-on-reset for core i |
| cfg_rdata | output | NCORE+1 | Configuration register contents |
| pad_tristate | output | 1 | Global pad float enable |
| boot_latch | output | 1 | One-cycle boot-mode capture strobe |
| dbg_rst_n | output | 1 | Debug domain reset, active low |
| sys_rst_n | output | 1 | System domain reset, active low |
| core_rst_n | output | NCORE | Per-core reset, active low |
| core_halt | output | NCORE | Per-core halt request |

## Verification
The bench builds the block with NCORE = 3 and SYNC_STAGES = 2. Three cores are enough to release one core while its neighbours stay held, and to give alternating halt-on-reset bits so that a swapped or shifted core index shows up. Two synchronizer stages make the release delay of R6 a fixed three edges, so the bench can check the release order cycle by cycle.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    // Strap value that selects wait-in-reset: bit 1 high, bit 0 low.
    localparam logic [1:0] WIR_STRAP = 2'b10;

    typedef struct packed {
        logic pad_ts;     // pad float enable
        logic dbg_rst_n;  // debug domain out of reset
        logic sys_rst_n;  // system domain out of reset
        logic boot_stb;   // boot capture strobe
        logic por_seen;   // power-on request was active last cycle
        logic wir;        // wait-in-reset selected
    } top_st_t;

    typedef struct packed {
        logic rst_n;  // core out of reset
        logic hold;   // held for the debugger
        logic halt;   // halt request
    } core_st_t;

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b1};
    end

    // Asserts as soon as the input falls, releases through STAGES flops.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rel_o = sh_q[STAGES-1];
endmodule

// File: rtl/rstctl_cfg.sv
module rstctl_cfg #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (clr)     cfg_d = '0;
        else if (we) cfg_d = wdata;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/rstctl_core.sv
module rstctl_core
    import rstctl_pkg::*;
(
    input  logic clk,
    input  logic sys_rst_n,
    input  logic wir,
    input  logic halt_en,
    input  logic release_i,
    output logic rst_n_o,
    output logic halt_o
);
    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sys_rst_n) begin
            st_d.hold  = wir;
            st_d.rst_n = 1'b0;
        end else begin
            if (release_i) st_d.hold = 1'b0;
            st_d.rst_n = !st_d.hold;
        end
        // While in reset the halt request follows its enable bit.
        if (!st_q.rst_n)     st_d.halt = halt_en;
        else if (release_i)  st_d.halt = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_n_o = st_q.rst_n;
    assign halt_o  = st_q.halt;
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int NCORE       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             full_n,
    input  logic             warm_n,
    input  logic [1:0]       dbg_strap,
    input  logic [NCORE-1:0] dbg_release,
    input  logic             cfg_we,
    input  logic [NCORE:0]   cfg_wdata,
    output logic [NCORE:0]   cfg_rdata,
    output logic             pad_tristate,
    output logic             boot_latch,
    output logic             dbg_rst_n,
    output logic             sys_rst_n,
    output logic [NCORE-1:0] core_rst_n,
    output logic [NCORE-1:0] core_halt
);
    localparam int CFG_W = NCORE + 1;

    logic por_rel, full_rel, warm_rel;
    logic por_act, hard_act, warm_act;
    logic [CFG_W-1:0] cfg;
    top_st_t st_d, st_q;

    rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync_por  (.clk(clk), .arst_n(por_n),  .rel_o(por_rel));
    rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync_full (.clk(clk), .arst_n(full_n), .rel_o(full_rel));
    rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync_warm (.clk(clk), .arst_n(warm_n), .rel_o(warm_rel));

    assign por_act  = !por_rel;
    assign hard_act = !por_rel || !full_rel;
    assign warm_act = !warm_rel && !cfg[0];

    // Debug-domain configuration: cleared only by the hard requests.
    rstctl_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .clr(hard_act), .we(cfg_we), .wdata(cfg_wdata), .cfg_o(cfg)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pad_ts    = por_act;
        st_d.dbg_rst_n = !hard_act;
        st_d.sys_rst_n = !hard_act && !warm_act && st_q.dbg_rst_n;
        st_d.boot_stb  = !hard_act && !st_q.dbg_rst_n;
        st_d.por_seen  = por_act;
        if (por_act)            st_d.wir = 1'b0;
        else if (st_q.por_seen) st_d.wir = (dbg_strap == WIR_STRAP);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        rstctl_core u_core (
            .clk       (clk),
            .sys_rst_n (st_q.sys_rst_n),
            .wir       (st_q.wir),
            .halt_en   (cfg[i+1]),
            .release_i (dbg_release[i]),
            .rst_n_o   (core_rst_n[i]),
            .halt_o    (core_halt[i])
        );
    end

    assign cfg_rdata    = cfg;
    assign pad_tristate = st_q.pad_ts;
    assign boot_latch   = st_q.boot_stb;
    assign dbg_rst_n    = st_q.dbg_rst_n;
    assign sys_rst_n    = st_q.sys_rst_n;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int NCORE = 4
) (
    input logic             clk,
    input logic             por_n,
    input logic             full_n,
    input logic             pad_tristate,
    input logic             boot_latch,
    input logic             dbg_rst_n,
    input logic             sys_rst_n,
    input logic [NCORE-1:0] core_rst_n
);
    assert_pad_in_dbg_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
        pad_tristate |-> !dbg_rst_n);

    assert_boot_on_dbg_rise_R3: assert property (@(posedge clk) disable iff (!por_n)
        boot_latch |-> $rose(dbg_rst_n));

    assert_dbg_survives_warm_R5: assert property (@(posedge clk) disable iff (!por_n || !full_n)
        ($past(por_n) && $past(full_n)) |-> !$fell(dbg_rst_n));

    assert_sys_after_dbg_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> $past(dbg_rst_n));

    assert_cores_follow_sys_R4: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> (core_rst_n == '0));
endmodule

bind rstctl_top rstctl_chk #(.NCORE(NCORE)) u_chk (
    .clk(clk), .por_n(por_n), .full_n(full_n), .pad_tristate(pad_tristate),
    .boot_latch(boot_latch), .dbg_rst_n(dbg_rst_n), .sys_rst_n(sys_rst_n),
    .core_rst_n(core_rst_n)
);

// File: tb/rstctl_top_test.sv
module rstctl_top_test;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          por_n = 1'b0, full_n = 1'b1, warm_n = 1'b1;
    logic [1:0]    dbg_strap = 2'b00;
    logic [NC-1:0] dbg_release = '0;
    logic          cfg_we = 1'b0;
    logic [NC:0]   cfg_wdata = '0;
    logic [NC:0]   cfg_rdata;
    logic          pad_tristate, boot_latch, dbg_rst_n, sys_rst_n;
    logic [NC-1:0] core_rst_n, core_halt;

    int n_chk = 0, n_bad = 0, boot_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rstctl_top #(.NCORE(NC), .SYNC_STAGES(2)) uut (
        .clk(clk), .por_n(por_n), .full_n(full_n), .warm_n(warm_n),
        .dbg_strap(dbg_strap), .dbg_release(dbg_release), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_tristate(pad_tristate),
        .boot_latch(boot_latch), .dbg_rst_n(dbg_rst_n), .sys_rst_n(sys_rst_n),
        .core_rst_n(core_rst_n), .core_halt(core_halt)
    );

    always @(negedge clk) if (boot_latch) boot_cnt++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic [NC:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_release(logic [NC-1:0] m);
        dbg_release = m;
        cyc(1);
        dbg_release = '0;
    endtask

    // Power-on request held, then released with a given strap value.
    task automatic do_por(logic [1:0] strap);
        dbg_strap = strap; por_n = 1'b0;
        cyc(4);
        por_n = 1'b1;
        cyc(8);
    endtask

    task automatic t_reset_state;
        cyc(3);
        chk("R1 pad", 32'(pad_tristate), 1);
        chk("R1 dbg", 32'(dbg_rst_n), 0);
        chk("R1 sys", 32'(sys_rst_n), 0);
        chk("R1 core", 32'(core_rst_n), 0);
    endtask

    task automatic t_por_release;
        int t_dbg = -1, t_sys = -1, t_core = -1, t_boot = -1, boots = 0;
        por_n = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            cyc(1);
            if (dbg_rst_n && t_dbg < 0) t_dbg = k;
            if (sys_rst_n && t_sys < 0) t_sys = k;
            if (core_rst_n == '1 && t_core < 0) t_core = k;
            if (boot_latch) begin boots++; t_boot = k; end
        end
        chk("R6 dbg edge", 32'(t_dbg), 3);
        chk("R6 sys edge", 32'(t_sys), 4);
        chk("R6 core edge", 32'(t_core), 5);
        chk("R3 boot count", 32'(boots), 1);
        chk("R3 boot edge", 32'(t_boot), 3);
        chk("R1 pad released", 32'(pad_tristate), 0);
        chk("R8 halt clear", 32'(core_halt), 0);
    endtask

    task automatic t_full_reset;
        int b0;
        cfg_write(4'b1110);
        chk("R9 readback", 32'(cfg_rdata), 32'hE);
        b0 = boot_cnt;
        full_n = 1'b0;
        cyc(3);
        chk("R2 pad low", 32'(pad_tristate), 0);
        chk("R2 dbg", 32'(dbg_rst_n), 0);
        chk("R2 sys", 32'(sys_rst_n), 0);
        chk("R2 core", 32'(core_rst_n), 0);
        chk("R9 cleared", 32'(cfg_rdata), 0);
        full_n = 1'b1;
        cyc(8);
        chk("R2 pad stays low", 32'(pad_tristate), 0);
        chk("R3 boot after full", 32'(boot_cnt - b0), 1);
        chk("R2 cores back", 32'(core_rst_n), 32'h7);
    endtask

    task automatic t_warm;
        int b0;
        cfg_write(4'b0100);
        b0 = boot_cnt;
        warm_n = 1'b0;
        cyc(1);
        chk("R4 sys first edge", 32'(sys_rst_n), 0);
        cyc(1);
        chk("R4 core second edge", 32'(core_rst_n), 0);
        chk("R5 dbg kept", 32'(dbg_rst_n), 1);
        warm_n = 1'b1;
        cyc(8);
        chk("R5 cfg kept", 32'(cfg_rdata), 32'h4);
        chk("R3 no boot on warm", 32'(boot_cnt - b0), 0);
        chk("R4 cores back", 32'(core_rst_n), 32'h7);
    endtask

    task automatic t_warm_masked;
        cfg_write(4'b0001);
        warm_n = 1'b0;
        cyc(6);
        chk("R4 masked sys", 32'(sys_rst_n), 1);
        chk("R4 masked core", 32'(core_rst_n), 32'h7);
        warm_n = 1'b1;
        cyc(3);
        cfg_write(4'b0000);
    endtask

    task automatic t_halt;
        cfg_write(4'b1010);
        warm_n = 1'b0;
        cyc(3);
        warm_n = 1'b1;
        cyc(8);
        chk("R8 cores out", 32'(core_rst_n), 32'h7);
        chk("R8 halt pattern", 32'(core_halt), 32'h5);
        pulse_release(3'b001);
        chk("R8 halt0 cleared", 32'(core_halt), 32'h4);
        pulse_release(3'b100);
        chk("R8 halt2 cleared", 32'(core_halt), 32'h0);
        cfg_write(4'b0000);
    endtask

    task automatic t_wir;
        do_por(2'b10);
        chk("R7 sys up", 32'(sys_rst_n), 1);
        chk("R7 cores held", 32'(core_rst_n), 0);
        pulse_release(3'b010);
        chk("R7 core1 only", 32'(core_rst_n), 32'h2);
        warm_n = 1'b0;
        cyc(3);
        pulse_release(3'b001);
        warm_n = 1'b1;
        cyc(8);
        chk("R7 ignored in reset", 32'(core_rst_n), 0);
        pulse_release(3'b111);
        chk("R7 all released", 32'(core_rst_n), 32'h7);
        dbg_strap = 2'b00;
        full_n = 1'b0;
        cyc(4);
        full_n = 1'b1;
        cyc(8);
        chk("R7 kept over full", 32'(core_rst_n), 0);
        pulse_release(3'b111);
        do_por(2'b01);
        chk("R7 other strap", 32'(core_rst_n), 32'h7);
    endtask

    initial begin
        t_reset_state();
        t_por_release();
        t_full_reset();
        t_warm();
        t_warm_masked();
        t_halt();
        t_wir();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule